// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine that sits beside a processor's main datapath. It owns a private result pair, HI and LO, which together form one double-width accumulator. A plain multiply writes the double-width product into the pair. Multiply-add and multiply-subtract fold the product into the pair's current value. Divide leaves the quotient in LO and the remainder in HI. Each operation chooses signed or unsigned arithmetic. One extra multiply returns only the low half of the product on the read-back port and leaves the pair untouched.

The pair is reached only through transfer operations. A move-to copies operand A into HI or LO. A move-from returns HI or LO on the read-back port one cycle later. Multiplies finish in the cycle they are accepted. Division is iterative: it retires `DIV_STEP` quotient bits per cycle, and `busy` stays high until the result reaches the pair. During that time the unit takes only move-from requests. It parks the first one and answers it with the fresh divide result in the cycle that `busy` falls.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO read as zero, `busy` is low and `rd_valid` is low.
- R2: `op_code` is decoded as follows: 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 divide, 4 low-half multiply, 5 read HI, 6 read LO, 7 write HI, 8 write LO. Codes 9 to 15 change nothing and produce no `rd_valid`.
- R3: An accepted multiply places the double-width product of A and B in {HI,LO}, with HI holding the upper half. The product is signed when `op_signed` is 1 and unsigned when it is 0, and the pair holds it from the next cycle.
- R4: An accepted multiply-add replaces {HI,LO} with {HI,LO} plus the product, taken modulo 2^(2·DATA_W).
- R5: An accepted multiply-subtract replaces {HI,LO} with {HI,LO} minus the product, taken modulo 2^(2·DATA_W).
- R6: An accepted low-half multiply raises `rd_valid` in the next cycle, with `rd_data` equal to the lower half of the product, and it leaves HI and LO unchanged.
- R7: An accepted read of HI or LO gives a one-cycle `rd_valid` pulse in the next cycle, carrying that register's value. A write of HI or LO copies `opnd_a` into it.
- R8: Divide leaves the quotient in LO and the remainder in HI. The signed form truncates the quotient toward zero and gives the remainder the sign of the dividend.
- R9: After a divide is accepted, `busy` is high for exactly DATA_W/DIV_STEP cycles, and HI/LO hold the result in the first cycle in which `busy` is low again.
- R10: A divide by zero keeps the same timing as any other divide and returns the unit to idle.
- R11: While `busy` is high, every operation other than a read of HI or LO is ignored: HI and LO do not change and `rd_valid` stays low.
- R12: A read of HI or LO issued while `busy` is high is held. It is answered with `rd_valid` in the cycle `busy` falls, carrying the new divide result. Only the first such read is kept, and `rd_valid` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (encoding in R2) |
| op_signed | input | 1 | 1 selects signed arithmetic |
| opnd_a | input | DATA_W | First operand, dividend, or value for a HI/LO write |
| opnd_b | input | DATA_W | Second operand or divisor |
| busy | output | 1 | A divide is in progress |
| rd_valid | output | 1 | `rd_data` carries a read-back or low-half product |
| rd_data | output | DATA_W | Read-back value |

## Verification
A divide can finish in the same cycle that a read of HI or LO arrives. The read may have been parked earlier, or it may be issued in the last busy cycle. The bench provokes both cases. It issues a read right after a divide starts, and it issues another read on exactly the last cycle in which `busy` is sampled high. In both cases it expects `rd_valid` in the cycle `busy` drops, carrying the new remainder or quotient, never the stale pair. The bench also drops writes and multiplies into the busy window and confirms afterwards that the pair holds only the divide result.

// File: rtl/hilo_pkg.sv
`timescale 1ns/1ps
package hilo_pkg;

   typedef enum logic [3:0] {
      HL_MUL   = 4'd0,
      HL_MADD  = 4'd1,
      HL_MSUB  = 4'd2,
      HL_DIV   = 4'd3,
      HL_MULLO = 4'd4,
      HL_RDHI  = 4'd5,
      HL_RDLO  = 4'd6,
      HL_WRHI  = 4'd7,
      HL_WRLO  = 4'd8
   } hl_op_e;

   function automatic logic hl_is_read(input logic [3:0] code);
      return (code == HL_RDHI) || (code == HL_RDLO);
   endfunction

endpackage

// File: rtl/hilo_mul.sv
`timescale 1ns/1ps
module hilo_mul #(
   parameter int W    = 32,
   parameter int IMPL = 0
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           sgn,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   logic [PW-1:0] xa;
   logic [PW-1:0] xb;

   // sign- or zero-extend to full width; the low PW bits of the product
   // are then correct for both interpretations
   assign xa = {{W{sgn & a[W-1]}}, a};
   assign xb = {{W{sgn & b[W-1]}}, b};

   if (IMPL == 0) begin : g_op
      assign prod = xa * xb;
   end else begin : g_arr
      logic [PW-1:0] acc [0:PW];
      assign acc[0] = '0;
      for (genvar i = 0; i < PW; i++) begin : g_row
         assign acc[i+1] = acc[i] + (xa[i] ? (xb << i) : '0);
      end
      assign prod = acc[PW];
   end

endmodule

// File: rtl/hilo_div.sv
`timescale 1ns/1ps
module hilo_div #(
   parameter int W    = 32,
   parameter int STEP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         sgn,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dvs,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int CYC = W / STEP;
   localparam int CW  = $clog2(CYC + 1);

   logic [W-1:0]  r_q;
   logic [W-1:0]  q_q;
   logic [W-1:0]  d_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          negq_q;
   logic          negr_q;

   logic [W-1:0]  mag_a;
   logic [W-1:0]  mag_b;

   assign mag_a = (sgn && dvd[W-1]) ? -dvd : dvd;
   assign mag_b = (sgn && dvs[W-1]) ? -dvs : dvs;

   // restoring steps chained STEP deep per cycle
   logic [W-1:0] r_ch [0:STEP];
   logic [W-1:0] q_ch [0:STEP];

   assign r_ch[0] = r_q;
   assign q_ch[0] = q_q;

   for (genvar k = 0; k < STEP; k++) begin : g_step
      logic [W:0]   sh;
      logic         ge;
      logic [W-1:0] sub;
      assign sh  = {r_ch[k], q_ch[k][W-1]};
      assign ge  = (sh >= {1'b0, d_q});
      assign sub = sh[W-1:0] - d_q;
      assign r_ch[k+1] = ge ? sub : sh[W-1:0];
      assign q_ch[k+1] = {q_ch[k][W-2:0], ge};
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == CW'(1));
   assign quo  = negq_q ? -q_ch[STEP] : q_ch[STEP];
   assign rem  = negr_q ? -r_ch[STEP] : r_ch[STEP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         r_q    <= '0;
         q_q    <= '0;
         d_q    <= '0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(CYC);
         r_q    <= '0;
         q_q    <= mag_a;
         d_q    <= mag_b;
         negq_q <= sgn & (dvd[W-1] ^ dvs[W-1]);
         negr_q <= sgn & dvd[W-1];
      end else if (busy_q) begin
         r_q   <= r_ch[STEP];
         q_q   <= q_ch[STEP];
         cnt_q <= cnt_q - CW'(1);
         if (done) busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/hilo_muldiv.sv
`timescale 1ns/1ps
module hilo_muldiv
   import hilo_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DIV_STEP = 1,
   parameter int MUL_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              op_signed,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PW      = 2 * DATA_W;
   localparam int DIV_CYC = DATA_W / DIV_STEP;

   if (DATA_W < 4) begin : g_bad_width
      $error("hilo_muldiv: DATA_W must be at least 4");
   end
   if (DIV_STEP < 1 || (DATA_W % DIV_STEP) != 0) begin : g_bad_step
      $error("hilo_muldiv: DIV_STEP must divide DATA_W");
   end
   if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_impl
      $error("hilo_muldiv: MUL_IMPL must be 0 or 1");
   end

   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] lo_q;
   logic              rd_valid_q;
   logic [DATA_W-1:0] rd_data_q;
   logic              pend_q;
   logic              pend_hi_q;

   logic [PW-1:0]     prod;
   logic              div_busy;
   logic              div_done;
   logic [DATA_W-1:0] div_quo;
   logic [DATA_W-1:0] div_rem;

   logic              acc;
   logic              rd_during_busy;
   logic              hold_hit;
   logic              hold_hi;
   logic [PW-1:0]     pair;
   logic [PW-1:0]     pair_add;
   logic [PW-1:0]     pair_sub;

   hilo_mul #(.W(DATA_W), .IMPL(MUL_IMPL)) u_mul (
      .a    (opnd_a),
      .b    (opnd_b),
      .sgn  (op_signed),
      .prod (prod)
   );

   hilo_div #(.W(DATA_W), .STEP(DIV_STEP)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc && (op_code == HL_DIV)),
      .sgn   (op_signed),
      .dvd   (opnd_a),
      .dvs   (opnd_b),
      .busy  (div_busy),
      .done  (div_done),
      .quo   (div_quo),
      .rem   (div_rem)
   );

   assign acc            = op_valid && !div_busy;
   assign rd_during_busy = op_valid && div_busy && hl_is_read(op_code);
   assign hold_hit       = div_done && (pend_q || rd_during_busy);
   assign hold_hi        = pend_q ? pend_hi_q : (op_code == HL_RDHI);

   assign pair     = {hi_q, lo_q};
   assign pair_add = pair + prod;
   assign pair_sub = pair - prod;

   // result pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (div_done) begin
         hi_q <= div_rem;
         lo_q <= div_quo;
      end else if (acc) begin
         case (op_code)
            HL_MUL:  {hi_q, lo_q} <= prod;
            HL_MADD: {hi_q, lo_q} <= pair_add;
            HL_MSUB: {hi_q, lo_q} <= pair_sub;
            HL_WRHI: hi_q <= opnd_a;
            HL_WRLO: lo_q <= opnd_a;
            default: ;
         endcase
      end
   end

   // parked read while dividing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_hi_q <= 1'b0;
      end else if (div_done) begin
         pend_q    <= 1'b0;
      end else if (rd_during_busy && !pend_q) begin
         pend_q    <= 1'b1;
         pend_hi_q <= (op_code == HL_RDHI);
      end
   end

   // read-back port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= 1'b0;
         if (hold_hit) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= hold_hi ? div_rem : div_quo;
         end else if (acc) begin
            case (op_code)
               HL_MULLO: begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= prod[DATA_W-1:0];
               end
               HL_RDHI: begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= hi_q;
               end
               HL_RDLO: begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= lo_q;
               end
               default: ;
            endcase
         end
      end
   end

   assign busy     = div_busy;
   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;

endmodule

// File: rtl/hilo_muldiv_chk.sv
`timescale 1ns/1ps
module hilo_muldiv_chk
   import hilo_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DIV_CYC = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic              busy,
   input logic              rd_valid,
   input logic [DATA_W-1:0] hi_q,
   input logic [DATA_W-1:0] lo_q
);
   localparam int RW = $clog2(DIV_CYC + 1) + 1;

   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + RW'(1);
      else           run_q <= '0;
   end

   // R9
   div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RW'(DIV_CYC)));

   // R9
   div_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == RW'(DIV_CYC)));

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(op_valid && (op_code == HL_DIV)));

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

   // R6
   mullo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy && (op_code == HL_MULLO)) |=> ($stable(hi_q) && $stable(lo_q)));

   // R12
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && busy));

   // R7
   rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(op_valid && !busy) || $fell(busy)));

endmodule

bind hilo_muldiv hilo_muldiv_chk #(.DATA_W(DATA_W), .DIV_CYC(DIV_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .busy     (busy),
   .rd_valid (rd_valid),
   .hi_q     (hi_q),
   .lo_q     (lo_q)
);

// File: tb/hilo_muldiv_tb.sv
`timescale 1ns/1ps
module hilo_muldiv_tb;
   import hilo_pkg::*;

   localparam int W    = 8;
   localparam int STEP = 1;
   localparam int CYC  = W / STEP;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_code = '0;
   logic         op_sgn = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic         busy;
   logic         rd_valid;
   logic [W-1:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 0;

   always #2.5 clk = ~clk;

   hilo_muldiv #(.DATA_W(W), .DIV_STEP(STEP), .MUL_IMPL(1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_signed (op_sgn),
      .opnd_a    (opa),
      .opnd_b    (opb),
      .busy      (busy),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic drive(input logic [3:0] c, input logic s,
                        input logic [W-1:0] a, input logic [W-1:0] b);
      op_valid = 1'b1; op_code = c; op_sgn = s; opa = a; opb = b;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic read_pair(output logic [2*W-1:0] v);
      logic [W-1:0] h, l;
      drive(HL_RDHI, 1'b0, '0, '0);
      h = rd_valid ? rd_data : 'x;
      drive(HL_RDLO, 1'b0, '0, '0);
      l = rd_valid ? rd_data : 'x;
      v = {h, l};
   endtask

   task automatic set_pair(input logic [W-1:0] h, input logic [W-1:0] l);
      drive(HL_WRHI, 1'b0, h, '0);
      drive(HL_WRLO, 1'b0, l, '0);
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy && cyc < 100) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   function automatic int ext(input logic [W-1:0] v, input logic s);
      return s ? int'($signed(v)) : int'(v);
   endfunction

   function automatic logic [2*W-1:0] prod_exp(input logic [W-1:0] a,
                                               input logic [W-1:0] b, input logic s);
      longint p;
      logic [63:0] t;
      p = longint'(ext(a, s)) * longint'(ext(b, s));
      t = p;
      return t[2*W-1:0];
   endfunction

   function automatic logic [2*W-1:0] div_exp(input logic [W-1:0] a,
                                              input logic [W-1:0] b, input logic s);
      int x, y, q, r;
      logic [31:0] qv, rv;
      x = ext(a, s); y = ext(b, s);
      q = x / y; r = x % y;
      qv = q; rv = r;
      return {rv[W-1:0], qv[W-1:0]};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      summary();
      $finish;
   end

   initial begin
      logic [2*W-1:0] v, e;
      logic [W-1:0]   a, b;
      int             cyc;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!busy && !rd_valid, "R1", {busy, rd_valid}, '0);
      read_pair(v);
      chk(v === '0, "R1", v, '0);

      // R7 writes, reads, single pulse
      set_pair(8'h12, 8'h34);
      read_pair(v);
      chk(v === 16'h1234, "R7", v, 16'h1234);
      @(negedge clk);
      chk(!rd_valid, "R7", rd_valid, 0);

      // R3 multiply sweep
      for (int s = 0; s < 2; s++) begin
         for (int ia = 0; ia < 17; ia++) begin
            for (int ib = 0; ib < 13; ib++) begin
               a = (ia == 16) ? 8'h80 : W'(ia * 17);
               b = (ib == 12) ? 8'h80 : W'(ib * 23);
               drive(HL_MUL, s[0], a, b);
               read_pair(v);
               e = prod_exp(a, b, s[0]);
               chk(v === e, "R3", v, e);
            end
         end
      end

      // R4 and R5 accumulate sweeps
      for (int s = 0; s < 2; s++) begin
         for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
               logic [W-1:0] h, l;
               a = W'(ia * 37 + 3);
               b = W'(ib * 51 + 128);
               h = W'(ia * 29 + ib * 71);
               l = W'(ib * 53 + 200);
               set_pair(h, l);
               drive(HL_MADD, s[0], a, b);
               read_pair(v);
               e = {h, l} + prod_exp(a, b, s[0]);
               chk(v === e, "R4", v, e);
               set_pair(h, l);
               drive(HL_MSUB, s[0], a, b);
               read_pair(v);
               e = {h, l} - prod_exp(a, b, s[0]);
               chk(v === e, "R5", v, e);
            end
         end
      end

      // R6 low-half multiply
      for (int s = 0; s < 2; s++) begin
         for (int ia = 0; ia < 6; ia++) begin
            a = W'(ia * 47 + 5);
            b = W'(255 - ia * 31);
            set_pair(8'h3C, 8'hA5);
            drive(HL_MULLO, s[0], a, b);
            e = prod_exp(a, b, s[0]);
            chk(rd_valid && rd_data === e[W-1:0], "R6", {7'd0, rd_valid, rd_data}, {8'd1, e[W-1:0]});
            read_pair(v);
            chk(v === 16'h3CA5, "R6", v, 16'h3CA5);
         end
      end

      // R2 unused codes
      for (int c = 9; c < 16; c++) begin
         set_pair(8'h5A, 8'hC3);
         drive(4'(c), 1'b1, 8'hFF, 8'hFF);
         chk(!rd_valid, "R2", rd_valid, 0);
         read_pair(v);
         chk(v === 16'h5AC3, "R2", v, 16'h5AC3);
      end

      // R8 and R9 divide sweep
      for (int s = 0; s < 2; s++) begin
         for (int ia = 0; ia < 21; ia++) begin
            for (int ib = 0; ib < 10; ib++) begin
               a = (ia == 20) ? 8'h80 : W'(ia * 13);
               b = (ib == 9) ? 8'hFF : W'(ib * 29 + 1);
               drive(HL_DIV, s[0], a, b);
               wait_idle(cyc);
               chk(cyc == CYC, "R9", 16'(cyc), 16'(CYC));
               read_pair(v);
               e = div_exp(a, b, s[0]);
               chk(v === e, "R8", v, e);
            end
         end
      end

      // R10 divide by zero keeps timing and returns to idle
      for (int s = 0; s < 2; s++) begin
         drive(HL_DIV, s[0], 8'h9B, 8'h00);
         wait_idle(cyc);
         chk(cyc == CYC, "R10", 16'(cyc), 16'(CYC));
         drive(HL_MUL, 1'b0, 8'd7, 8'd9);
         read_pair(v);
         chk(v === 16'd63, "R10", v, 16'd63);
      end

      // R11 operations ignored while busy
      drive(HL_DIV, 1'b0, 8'd100, 8'd7);
      drive(HL_WRHI, 1'b0, 8'h55, '0);
      drive(HL_MUL, 1'b0, 8'd9, 8'd9);
      drive(HL_MULLO, 1'b0, 8'd3, 8'd3);
      chk(!rd_valid, "R11", rd_valid, 0);
      drive(HL_MADD, 1'b0, 8'd9, 8'd9);
      wait_idle(cyc);
      read_pair(v);
      chk(v === {8'd2, 8'd14}, "R11", v, {8'd2, 8'd14});

      // R12 read parked early; second read dropped
      drive(HL_DIV, 1'b0, 8'd200, 8'd9);
      drive(HL_RDHI, 1'b0, '0, '0);
      chk(!rd_valid, "R12", rd_valid, 0);
      drive(HL_RDLO, 1'b0, '0, '0);
      chk(!rd_valid, "R12", rd_valid, 0);
      wait_idle(cyc);
      chk(rd_valid && rd_data === 8'd2, "R12", {7'd0, rd_valid, rd_data}, {8'd1, 8'd2});
      @(negedge clk);
      chk(!rd_valid, "R12", rd_valid, 0);

      // R12 read issued in the final busy cycle
      drive(HL_DIV, 1'b1, 8'hC4, 8'd5);
      repeat (CYC - 1) @(negedge clk);
      chk(busy, "R12", busy, 1);
      drive(HL_RDLO, 1'b0, '0, '0);
      e = div_exp(8'hC4, 8'd5, 1'b1);
      chk(!busy && rd_valid && rd_data === e[W-1:0], "R12",
          {6'd0, busy, rd_valid, rd_data}, {8'd1, e[W-1:0]});

      summary();
      $finish;
   end

endmodule